// File: doc/BRIEF.md
# Auxiliary Channel Ownership Lock

This block arbitrates one auxiliary channel between two agents: software on a memory-mapped register bus, and a hardware engine that can run channel transactions by itself, for example while a panel self-refresh feature is active. Exactly one agent may own the channel at a time. The block decodes one 32-bit register, keeps an ownership state machine and reports the current owner. Each channel gets its own instance.

Software takes the lock through the side effect of a read. Once the enable bit is set, every read of the register is a lock request. The status bit in the returned data tells software whether it now holds the lock. Software gives the lock back by writing the register with the status bit set, or by clearing the enable bit. The hardware engine uses a request/grant pair instead and keeps the lock for as long as it holds its request high. The remaining 30 bits are plain storage, so that software can do read-modify-write on the register without losing them.

Top module: `chan_lock`

## Requirements
- R1: After reset, the enable bit and the reserved bits are 0, `owner` is 2'b00 (free) and `hw_gnt` is 0.
- R2: Register layout: bit 31 is the enable bit, bit 30 is the lock status, and bits 29:0 are reserved. A write to the lock address stores bits 31 and 29:0. A read returns the stored enable bit and the stored reserved bits unchanged.
- R3: While the enable bit is 0, a read has no acquire effect. The status bit reads 1 and `owner` does not change.
- R4: While the enable bit is 1 and the lock is free, a read moves `owner` to software (2'b01) at the next clock edge. The data returned combinationally in that same read cycle has status 0. A read while software already owns the lock also returns status 0.
- R5: A read while the hardware engine owns the lock returns status 1 and leaves the hardware engine as owner.
- R6: While software owns the lock, a write to the lock address with bit 30 = 1 frees the lock at the next edge.
- R7: While software owns the lock, a write with bit 31 = 0 frees the lock at the next edge.
- R8: A release write (bit 30 = 1) while software does not own the lock has no effect on ownership.
- R9: When the lock is free, `hw_req` = 1 gives the lock to the hardware engine at the next edge. `owner` becomes 2'b10 and `hw_gnt` becomes 1. The engine keeps the lock until `hw_req` is sampled low, and `hw_gnt` falls at that edge.
- R10: If an acquiring software read and `hw_req` occur in the same cycle while the lock is free, software wins. The hardware grant follows one edge after the software release.
- R11: `hw_gnt` is never 1 while `owner` shows software ownership.
- R12: An access to any other address has no effect and reads 0. If a read and a write to the lock address occur in the same cycle, the write takes effect, the read has no side effect, and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally in the read cycle |
| hw_req | input | 1 | Lock request from the hardware engine, held for the whole tenure |
| hw_gnt | output | 1 | Lock granted to the hardware engine |
| owner | output | 2 | Current owner: 00 free, 01 software, 10 hardware |

## Verification
Directed sequences walk through the handshakes that separate the owners. They cover a read before and after enable, a repeated read while software holds the lock, a read while the hardware engine holds it, release by the status bit and release by clearing enable, an ignored release during hardware tenure, and the same-cycle tie between a read and `hw_req`. The random phase mixes reads, writes, hits on other addresses and a `hw_req` that toggles. This exposes any error in priority or in the timing of the release edge against a cycle-accurate bench model. Reserved-bit patterns written at random confirm that the stored bits never mix with the two control bits.

// File: rtl/chan_lock_pkg.sv
package chan_lock_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned EN_POS = WORD_W - 1;
  localparam int unsigned ST_POS = WORD_W - 2;
  localparam int unsigned RSV_W  = WORD_W - 2;

  typedef enum logic [1:0] {
    OWN_FREE = 2'b00,
    OWN_SW   = 2'b01,
    OWN_HW   = 2'b10
  } owner_e;

  // A software write returns the lock if it sets status or clears enable.
  function automatic logic is_release(input logic [WORD_W-1:0] wd);
    return wd[ST_POS] | ~wd[EN_POS];
  endfunction

  // Status seen by software: 0 only when it holds the lock after the access.
  function automatic logic status_of(input owner_e after);
    return (after != OWN_SW);
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(input logic en,
                                                  input logic st,
                                                  input logic [RSV_W-1:0] rsv);
    return {en, st, rsv};
  endfunction

endpackage

// File: rtl/chan_lock_dec.sv
module chan_lock_dec #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h2C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit
);

  logic sel;

  always_comb begin
    sel    = (addr == LOCK_ADDR);
    wr_hit = sel & wr;
    // a write in the same cycle cancels the read side effect
    rd_hit = sel & rd & ~wr;
  end

endmodule

// File: rtl/chan_lock_fsm.sv
module chan_lock_fsm
  import chan_lock_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sw_acq,
  input  logic   sw_rel,
  input  logic   hw_req,
  output owner_e own_q,
  output owner_e own_nxt,
  output logic   hw_gnt
);

  always_comb begin
    own_nxt = own_q;
    unique case (own_q)
      OWN_FREE: begin
        if (sw_acq)      own_nxt = OWN_SW;
        else if (hw_req) own_nxt = OWN_HW;
      end
      OWN_SW: begin
        if (sw_rel) own_nxt = OWN_FREE;
      end
      OWN_HW: begin
        if (!hw_req) own_nxt = OWN_FREE;
      end
      default: own_nxt = OWN_FREE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_q <= OWN_FREE;
    else        own_q <= own_nxt;
  end

  assign hw_gnt = (own_q == OWN_HW);

endmodule

// File: rtl/chan_lock_regs.sv
module chan_lock_regs
  import chan_lock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_hit,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wdata,
  input  owner_e            own_nxt,
  output logic              en_q,
  output logic [WORD_W-1:0] rdata
);

  logic [RSV_W-1:0] rsv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      rsv_q <= '0;
    end else if (wr_hit) begin
      en_q  <= wdata[EN_POS];
      rsv_q <= wdata[RSV_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) rdata = pack_word(en_q, status_of(own_nxt), rsv_q);
  end

endmodule

// File: rtl/chan_lock.sv
module chan_lock
  import chan_lock_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              hw_req,
  output logic              hw_gnt,
  output logic [1:0]        owner
);

  logic   rd_hit;
  logic   wr_hit;
  logic   en_q;
  logic   sw_acq;
  logic   sw_rel;
  owner_e own_q;
  owner_e own_nxt;

  chan_lock_dec #(.ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)) u_dec (
    .addr   (bus_addr),
    .rd     (bus_rd),
    .wr     (bus_wr),
    .rd_hit (rd_hit),
    .wr_hit (wr_hit)
  );

  assign sw_acq = rd_hit & en_q;
  assign sw_rel = wr_hit & is_release(bus_wdata);

  chan_lock_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .sw_acq  (sw_acq),
    .sw_rel  (sw_rel),
    .hw_req  (hw_req),
    .own_q   (own_q),
    .own_nxt (own_nxt),
    .hw_gnt  (hw_gnt)
  );

  chan_lock_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_hit  (rd_hit),
    .wr_hit  (wr_hit),
    .wdata   (bus_wdata),
    .own_nxt (own_nxt),
    .en_q    (en_q),
    .rdata   (bus_rdata)
  );

  assign owner = own_q;

endmodule

// File: rtl/chan_lock_chk.sv
module chan_lock_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_hit,
  input logic        wr_hit,
  input logic        en_q,
  input logic        hw_req,
  input logic        hw_gnt,
  input logic [1:0]  owner,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata
);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_gnt && owner == 2'b01));

  a_r1_owner_code: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  a_r9_grant_from_free: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_gnt) |-> $past(owner) == 2'b00);

  a_r9_hw_release: assert property (@(posedge clk) disable iff (!rst_n)
    hw_gnt && !hw_req |=> !hw_gnt);

  a_r4_acquire: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && en_q && owner == 2'b00 |=> owner == 2'b01);

  a_r4_status_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && !bus_rdata[30] |=> owner == 2'b01);

  a_r5_busy_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit && owner == 2'b10 |-> bus_rdata[30]);

  a_r8_release_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && owner == 2'b10 && hw_req |=> owner == 2'b10);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit && owner == 2'b01 && bus_wdata[30] |=> owner != 2'b01);

endmodule

bind chan_lock chan_lock_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_hit    (rd_hit),
  .wr_hit    (wr_hit),
  .en_q      (en_q),
  .hw_req    (hw_req),
  .hw_gnt    (hw_gnt),
  .owner     (owner),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata)
);

// File: tb/chan_lock_test.sv
`timescale 1ns/1ps
module chan_lock_test;

  localparam logic [7:0] LA = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hw_req = 1'b0;
  logic        hw_gnt;
  logic [1:0]  owner;

  int checks = 0;
  int fails  = 0;

  // bench model
  logic        m_en  = 1'b0;
  logic [29:0] m_rsv = '0;
  logic [1:0]  m_own = 2'b00;

  always #2 clk = ~clk;

  chan_lock uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .hw_req(hw_req), .hw_gnt(hw_gnt), .owner(owner)
  );

  function automatic logic [1:0] next_own(input logic [1:0] cur, input logic en,
      input logic rhit, input logic whit, input logic [31:0] wd, input logic req);
    if (cur == 2'b00) return (rhit && en) ? 2'b01 : (req ? 2'b10 : 2'b00);
    if (cur == 2'b01) return (whit && (wd[30] || !wd[31])) ? 2'b00 : 2'b01;
    return req ? 2'b10 : 2'b00;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic [7:0] a, input logic rd,
                     input logic wr, input logic [31:0] wd, input logic req);
    logic rhit, whit;
    logic [1:0] nxt;
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; hw_req = req;
    rhit = rd && !wr && (a == LA);
    whit = wr && (a == LA);
    nxt = next_own(m_own, m_en, rhit, whit, wd, req);
    exp_rd = rhit ? {m_en, (nxt != 2'b01), m_rsv} : 32'h0;
    #1;
    check({tag, " rdata"}, bus_rdata, exp_rd);
    @(posedge clk);
    m_own = nxt;
    if (whit) begin m_en = wd[31]; m_rsv = wd[29:0]; end
    #1;
    check({tag, " owner"}, {30'h0, owner}, {30'h0, m_own});
    check({tag, " hw_gnt"}, {31'h0, hw_gnt}, {31'h0, (m_own == 2'b10)});
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 owner at reset", {30'h0, owner}, 32'h0);
    check("R1 hw_gnt at reset", {31'h0, hw_gnt}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    cyc("R1 R3 disabled read", LA, 1, 0, 0, 0);
    cyc("R2 enable write", LA, 0, 1, 32'h8123_4567, 0);
    cyc("R2 R4 acquire read", LA, 1, 0, 0, 0);
    cyc("R4 repeat read", LA, 1, 0, 0, 0);
    cyc("R11 hw waits", LA, 0, 0, 0, 1);
    cyc("R6 R10 release", LA, 0, 1, 32'hC000_0ABC, 1);
    cyc("R10 hw granted", LA, 0, 0, 0, 1);
    cyc("R5 busy read", LA, 1, 0, 0, 1);
    cyc("R8 release ignored", LA, 0, 1, 32'hC000_0001, 1);
    cyc("R9 hw drop", LA, 0, 0, 0, 0);
    cyc("R10 tie", LA, 1, 0, 0, 1);
    cyc("R10 hold", LA, 0, 0, 0, 1);
    cyc("R7 disable frees", LA, 0, 1, 32'h0000_0055, 1);
    cyc("R9 hw after disable", LA, 0, 0, 0, 1);
    cyc("R3 disabled read hw", LA, 1, 0, 0, 1);
    cyc("R9 hw drop2", LA, 0, 0, 0, 0);
    cyc("R12 other addr write", 8'h2D, 0, 1, 32'h8000_0000, 0);
    cyc("R12 other addr read", 8'h10, 1, 0, 0, 0);
    cyc("R12 enable", LA, 0, 1, 32'h8000_0000, 0);
    cyc("R12 rd+wr", LA, 1, 1, 32'hBFFF_FFFF, 0);
    cyc("R12 no acquire", LA, 0, 0, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      logic r, w, q;
      logic [31:0] d;
      a = ($urandom % 4 != 0) ? LA : 8'($urandom);
      r = ($urandom % 2) == 1;
      w = ($urandom % 4) == 0;
      d = $urandom;
      if ($urandom % 3 == 0) d[31] = 1'b1;
      q = ($urandom % 8 == 0) ? ~hw_req : hw_req;
      cyc("R4-random", a, r, w, d, q);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule